// File: doc/BRIEF.md
# Program Memory Source and Status Slot Selector

This block decides, for a four-bit controller whose program counter is split into a bank and an in-bank address, whether the current instruction fetch is served by the on-chip program store or by external memory. The choice comes from a single strap pin. The pin is sampled twice in every machine cycle: once while SYNC is low and once while SYNC is high. Because of this, wiring the pin low, high, to SYNC or to inverted SYNC gives four distinct memory policies without any extra pins.

The same block drives the time-shared STATUS pin. Each machine cycle has four clock slots, T1, T3, T5 and T7, marked by one-hot strobes. In each slot the pin shows a different internal flag. In T1 it shows whether the data bus is left undriven. In T3 it shows that the BL register equals 13. In T5 it shows carry, and in T7 it shows the skip flag.

The two captured samples are held as a four-state mode register. The states are MODE_LOW (code 00), MODE_SYNC (01), MODE_NSYNC (10) and MODE_HIGH (11). Bit 1 of the code is the sample taken while SYNC is low, and bit 0 is the sample taken while SYNC is high. There are two transitions. The low-phase capture replaces bit 1 at the end of T1 when SYNC is low. The high-phase capture replaces bit 0 at the end of T5 when SYNC is high. In every other cycle the state holds.

Top module: `memsrc_status_top`

## Requirements
- R1: On a rising clock edge with slot_t1 high and sync low, the value of mode_pin becomes bit 1 of the mode code (the SYNC-low sample).
- R2: On a rising clock edge with slot_t5 high and sync high, the value of mode_pin becomes bit 0 of the mode code (the SYNC-high sample).
- R3: The mode code holds on every other edge, including slot_t1 with sync high and slot_t5 with sync low.
- R4: While rst_n is low the mode code is 00 (MODE_LOW), so bank 0 selects internal memory and other banks select external memory.
- R5: With mode code 00, use_internal is 1 exactly when bank equals 0.
- R6: With mode code 01 (pin follows SYNC), use_internal is 0 for every bank.
- R7: With mode codes 10 (pin follows inverted SYNC) and 11 (pin high), use_internal is 1 for every bank.
- R8: use_internal is combinational in bank and follows a bank change without a clock edge.
- R9: While slot_t1 is high, status equals the inverse of bus_driven.
- R10: status equals bl_is_13 while slot_t3 is high, carry while slot_t5 is high, and skip while slot_t7 is high.
- R11: When no slot strobe is high, status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; samples are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_t1 | input | 1 | Slot strobe T1 (one-hot with the other strobes) |
| slot_t3 | input | 1 | Slot strobe T3 |
| slot_t5 | input | 1 | Slot strobe T5 |
| slot_t7 | input | 1 | Slot strobe T7 |
| sync | input | 1 | Machine-cycle phase: low for fetch, high for decode |
| bank | input | 3 | Current program bank |
| mode_pin | input | 1 | Memory-source strap pin |
| bus_driven | input | 1 | Data bus is being driven by the controller |
| bl_is_13 | input | 1 | BL register equals 13 |
| carry | input | 1 | Carry flag |
| skip | input | 1 | Skip flag |
| use_internal | output | 1 | 1 selects internal program memory, 0 selects external |
| status | output | 1 | Time-multiplexed status flag |

## Verification
In slot T5, the high-phase capture of the strap pin coincides with the carry flag being shown on status. In T1, the low-phase capture coincides with the inverted bus flag. The bench drives every vector as a full four-slot cycle in which the pin value, the flags and the bank all change together. It checks status in each slot before the capturing edge, and checks use_internal after the cycle ends, so a capture that disturbed the multiplexer, or a multiplexer that read the wrong slot, shows up as a mismatch. Directed steps then apply a strobe in the wrong SYNC phase and change the bank within a single low clock phase.

// File: rtl/memsrc_pkg.sv
package memsrc_pkg;

    localparam int BANK_W    = 3;
    localparam int NUM_SLOTS = 4;

    // bit 1: SYNC-low sample, bit 0: SYNC-high sample
    typedef enum logic [1:0] {
        MODE_LOW   = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_NSYNC = 2'b10,
        MODE_HIGH  = 2'b11
    } mem_mode_e;

endpackage

// File: rtl/memsrc_mode_capture.sv
module memsrc_mode_capture
    import memsrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slot_t1,
    input  logic      slot_t5,
    input  logic      sync,
    input  logic      mode_pin,
    output mem_mode_e mode
);

    mem_mode_e state_q;
    mem_mode_e state_d;
    logic      lo_en;
    logic      hi_en;

    assign lo_en = slot_t1 && !sync;
    assign hi_en = slot_t5 && sync;

    // next-state process: low-phase capture and high-phase capture
    always_comb begin
        logic [1:0] code;
        code = state_q;
        if (lo_en) code[1] = mode_pin;
        if (hi_en) code[0] = mode_pin;
        unique case (code)
            2'b00:   state_d = MODE_LOW;
            2'b01:   state_d = MODE_SYNC;
            2'b10:   state_d = MODE_NSYNC;
            default: state_d = MODE_HIGH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_LOW;
        else        state_q <= state_d;
    end

    assign mode = state_q;

    // R1
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_t1 && !sync) |=> (mode[1] == $past(mode_pin)));

    // R2
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_t5 && sync) |=> (mode[0] == $past(mode_pin)));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((slot_t1 && !sync) || (slot_t5 && sync)) |=> $stable(mode));

endmodule

// File: rtl/memsrc_rom_select.sv
module memsrc_rom_select
    import memsrc_pkg::*;
#(
    parameter int BANK_BITS = BANK_W
) (
    input  mem_mode_e            mode,
    input  logic [BANK_BITS-1:0] bank,
    output logic                 use_internal
);

    logic bank_zero;
    assign bank_zero = (bank == '0);

    // output process, one arm per mode state
    always_comb begin
        unique case (mode)
            MODE_LOW:   use_internal = bank_zero;
            MODE_SYNC:  use_internal = 1'b0;
            MODE_NSYNC: use_internal = 1'b1;
            MODE_HIGH:  use_internal = 1'b1;
            default:    use_internal = 1'b1;
        endcase
    end

endmodule

// File: rtl/memsrc_status_mux.sv
module memsrc_status_mux #(
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] slot_strb,
    input  logic [SLOTS-1:0] slot_flag,
    output logic             status
);

    logic [SLOTS-1:0] term;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_term
            assign term[g] = slot_strb[g] & slot_flag[g];
        end
    endgenerate

    assign status = |term;

    // R11 relies on one-hot strobes
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_strb));

    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strb == '0) |-> !status);

endmodule

// File: rtl/memsrc_status_top.sv
module memsrc_status_top
    import memsrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_t1,
    input  logic              slot_t3,
    input  logic              slot_t5,
    input  logic              slot_t7,
    input  logic              sync,
    input  logic [BANK_W-1:0] bank,
    input  logic              mode_pin,
    input  logic              bus_driven,
    input  logic              bl_is_13,
    input  logic              carry,
    input  logic              skip,
    output logic              use_internal,
    output logic              status
);

    mem_mode_e            mode;
    logic [NUM_SLOTS-1:0] strb;
    logic [NUM_SLOTS-1:0] flag;

    assign strb = {slot_t7, slot_t5, slot_t3, slot_t1};
    assign flag = {skip, carry, bl_is_13, !bus_driven};

    memsrc_mode_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_t1  (slot_t1),
        .slot_t5  (slot_t5),
        .sync     (sync),
        .mode_pin (mode_pin),
        .mode     (mode)
    );

    memsrc_rom_select #(.BANK_BITS(BANK_W)) u_select (
        .mode         (mode),
        .bank         (bank),
        .use_internal (use_internal)
    );

    memsrc_status_mux #(.SLOTS(NUM_SLOTS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_strb (strb),
        .slot_flag (flag),
        .status    (status)
    );

    // R6
    sync_mode_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SYNC) |-> !use_internal);

    // R7
    high_mode_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> use_internal);

    // R9
    t1_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_t1 |-> (status == !bus_driven));

    // R10
    t7_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_t7 |-> (status == skip));

endmodule

// File: tb/memsrc_status_top_bench.sv
module memsrc_status_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_t1 = 1'b0, slot_t3 = 1'b0, slot_t5 = 1'b0, slot_t7 = 1'b0;
    logic       sync = 1'b0;
    logic [2:0] bank = 3'd0;
    logic       mode_pin = 1'b0;
    logic       bus_driven = 1'b0, bl_is_13 = 1'b0, carry = 1'b0, skip = 1'b0;
    logic       use_internal, status;

    int vectors = 0;
    int misses  = 0;

    always #2.5 clk = ~clk;

    memsrc_status_top u_memsrc_status_top (
        .clk(clk), .rst_n(rst_n),
        .slot_t1(slot_t1), .slot_t3(slot_t3), .slot_t5(slot_t5), .slot_t7(slot_t7),
        .sync(sync), .bank(bank), .mode_pin(mode_pin),
        .bus_driven(bus_driven), .bl_is_13(bl_is_13), .carry(carry), .skip(skip),
        .use_internal(use_internal), .status(status)
    );

    // {lo sample, hi sample, bank[2:0], exp internal,
    //  flags {bus_driven, bl_is_13, carry, skip}, exp status {T1, T3, T5, T7}}
    localparam logic [13:0] VEC [10] = '{
        {1'b0, 1'b0, 3'd0, 1'b1, 4'b0000, 4'b1000},
        {1'b0, 1'b0, 3'd1, 1'b0, 4'b1111, 4'b0111},
        {1'b0, 1'b0, 3'd7, 1'b0, 4'b1010, 4'b0010},
        {1'b0, 1'b1, 3'd0, 1'b0, 4'b0101, 4'b1101},
        {1'b0, 1'b1, 3'd5, 1'b0, 4'b1001, 4'b0001},
        {1'b1, 1'b0, 3'd0, 1'b1, 4'b0110, 4'b1110},
        {1'b1, 1'b0, 3'd3, 1'b1, 4'b1100, 4'b0100},
        {1'b1, 1'b1, 3'd0, 1'b1, 4'b0011, 4'b1011},
        {1'b1, 1'b1, 3'd6, 1'b1, 4'b1000, 4'b0000},
        {1'b0, 1'b0, 3'd4, 1'b0, 4'b0001, 4'b1001}
    };

    task automatic check(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_slot(input int s);
        slot_t1 = (s == 0);
        slot_t3 = (s == 1);
        slot_t5 = (s == 2);
        slot_t7 = (s == 3);
    endtask

    // one machine cycle: T1,T3 with SYNC low, T5,T7 with SYNC high
    task automatic run_cycle(input logic lo, input logic hi, input logic [2:0] bk,
                             input logic [3:0] fl, input logic [3:0] exp_st,
                             input logic exp_int, input string tag);
        bank = bk;
        {bus_driven, bl_is_13, carry, skip} = fl;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            set_slot(s);
            sync     = (s >= 2);
            mode_pin = (s < 2) ? lo : hi;
            #1;
            check(status, exp_st[3-s], (s == 0) ? "R9" : "R10");
        end
        @(negedge clk);
        set_slot(-1);
        #1;
        check(status, 1'b0, "R11");
        check(use_internal, exp_int, tag);
    endtask

    initial begin
        #100000;
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R4: reset state
        repeat (2) @(negedge clk);
        bank = 3'd0; #1;
        check(use_internal, 1'b1, "R4");
        bank = 3'd2; #1;
        check(use_internal, 1'b0, "R4");
        check(status, 1'b0, "R11");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            logic [13:0] v;
            string       tag;
            v = VEC[i];
            case (v[12:11] == 2'b00 ? 0 : (v[13:12] == 2'b01 ? 1 : 2))
                0:       tag = "R5";
                1:       tag = "R6";
                default: tag = "R7";
            endcase
            if (v[13:12] == 2'b00) tag = "R5";
            else if (v[13:12] == 2'b01) tag = "R6";
            else tag = "R7";
            run_cycle(v[13], v[12], v[11:9], v[7:4], v[3:0], v[8], {tag, "/R1/R2"});
        end

        // R8: bank change without a clock edge, mode 00 in place
        @(negedge clk);
        bank = 3'd0; #1;
        check(use_internal, 1'b1, "R8");
        bank = 3'd3; #1;
        check(use_internal, 1'b0, "R8");

        // R3: T5 strobe in the SYNC-low phase must not capture
        @(negedge clk);
        slot_t5 = 1'b1; sync = 1'b0; mode_pin = 1'b1; bank = 3'd0;
        @(negedge clk);
        set_slot(-1); #1;
        check(use_internal, 1'b1, "R3");

        // go to mode 11, then a T1 strobe in the SYNC-high phase must not capture
        run_cycle(1'b1, 1'b1, 3'd5, 4'b0000, 4'b1000, 1'b1, "R7");
        @(negedge clk);
        slot_t1 = 1'b1; sync = 1'b1; mode_pin = 1'b0;
        @(negedge clk);
        set_slot(-1); #1;
        check(use_internal, 1'b1, "R3");

        // R4: reset mid-operation returns to MODE_LOW
        @(negedge clk);
        rst_n = 1'b0; bank = 3'd5; #1;
        check(use_internal, 1'b0, "R4");
        bank = 3'd0; #1;
        check(use_internal, 1'b1, "R4");
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule